// File: doc/BRIEF.md
# Programmable Port Pattern Matcher

This block watches a parallel input port and raises a sticky flag when the port meets a pattern that software sets up. The block first samples each input bit every clock. A per-bit inversion mask is applied before sampling. An optional per-bit ones-catcher holds any sampled 1 until software clears it.

Three per-bit registers (mask, edge select and polarity) give each bit one of six conditions:
- ignored;
- any transition;
- level zero;
- level one;
- falling edge;
- rising edge.

A two-bit mode then combines the bit results as off, AND, OR, or OR with a priority number. The priority number is the index of the highest matching bit, for use by vector logic.

Optionally, the port data is frozen at the moment of a match and held until the flag is cleared. An event pulse goes to the interrupt logic. The pulse fires on match cycles only, or also on any change of the sampled data, as selected by an option.

Top module: `port_pattern_matcher`

## Requirements
- R1: While reset is asserted and right after it, `match_flag`, `prio_idx`, `data_out` and `irq_evt` are all zero.
- R2: A 1 in `inv_mask[i]` inverts input bit i before it is sampled and before any pattern condition is evaluated.
- R3: The per-bit condition for (`pat_mask`, `pat_edge`) = (1,0) is a level condition. `pat_pol` = 1 means the bit must be 1, and `pat_pol` = 0 means the bit must be 0.
- R4: The condition for (`pat_mask`, `pat_edge`) = (1,1) is an edge condition. `pat_pol` = 1 means 0-to-1 and `pat_pol` = 0 means 1-to-0. It compares the current sample with the previous clock's sample and is true for one cycle only.
- R5: The condition for (`pat_mask`, `pat_edge`) = (0,1) is true for one cycle when the sampled bit changes in either direction.
- R6: A bit with (`pat_mask`, `pat_edge`) = (0,0) is ignored. `combine_mode` = 0 never matches. When every bit is ignored, no mode ever matches.
- R7: With `combine_mode` = 1 (AND), a match needs every non-ignored bit to meet its condition in the same cycle.
- R8: With `combine_mode` = 2 (OR), one non-ignored bit meeting its condition is a match.
- R9: With `combine_mode` = 3 (OR-priority), matching works as in OR. On each match, `prio_idx` loads the index of the highest-numbered matching bit (bit 7 has the highest priority). Between matches, `prio_idx` holds its value.
- R10: `match_flag` sets two clock edges after the input that causes a match is applied. It stays set until `flag_clr` is high at a clock edge. If a match is present in the same cycle as the clear, the set wins.
- R11: `data_out` shows the conditioned sample, two edges behind the pins. When `latch_en` = 1, the sample is captured in the match cycle and held while `match_flag` is set. It resumes tracking on the edge where `flag_clr` clears the flag.
- R12: When `catch_en[i]` = 1, a sampled 1 on bit i is held until an edge where `flag_clr` is high.
- R13: `irq_evt` is a one-cycle pulse aligned with the flag setting. With `match_only` = 1, it pulses only for a match. With `match_only` = 0, it also pulses when any sampled bit differs from its previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | WIDTH | Raw port input bits |
| inv_mask | input | WIDTH | Per-bit input inversion (1 = invert) |
| catch_en | input | WIDTH | Per-bit ones-catcher enable |
| pat_pol | input | WIDTH | Per-bit pattern polarity |
| pat_edge | input | WIDTH | Per-bit pattern edge select |
| pat_mask | input | WIDTH | Per-bit pattern mask |
| combine_mode | input | 2 | 0 off, 1 AND, 2 OR, 3 OR-priority |
| latch_en | input | 1 | Freeze data on match |
| match_only | input | 1 | Event pulse on matches only |
| flag_clr | input | 1 | Clear flag and caught ones |
| match_flag | output | 1 | Sticky match flag |
| prio_idx | output | IDX_W | Highest matching bit number |
| data_out | output | WIDTH | Conditioned or latched port data |
| irq_evt | output | 1 | One-cycle event pulse |

## Verification
A wrong stored previous sample would show up at the ports within two edges. Edge conditions would then either miss their pulse on `match_flag`, or set the flag when no transition happened. A wrong catcher or latch state shows directly on `data_out` on the next edge. The test checks it after the input changes and again after a clear. A stale priority register shows as a wrong `prio_idx` on the second match. The test therefore applies two matches in a row with different highest bits.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
    typedef enum logic [1:0] {
        CMB_OFF  = 2'd0,
        CMB_AND  = 2'd1,
        CMB_OR   = 2'd2,
        CMB_PRIO = 2'd3
    } combine_e;
endpackage

// File: rtl/ppm_sampler.sv
module ppm_sampler #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] inv_mask,
    input  logic [WIDTH-1:0] catch_en,
    input  logic             flag_clr,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);
    typedef struct packed {
        logic [WIDTH-1:0] samp;
        logic [WIDTH-1:0] prev;
    } samp_t;

    samp_t st_d, st_q;
    logic [WIDTH-1:0] held;

    always_comb begin
        st_d      = st_q;
        held      = st_q.samp & catch_en & ~{WIDTH{flag_clr}};
        st_d.samp = (pin_in ^ inv_mask) | held;
        st_d.prev = st_q.samp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o  = st_q.samp;
    assign prev_o = st_q.prev;

    AST_CATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr |=> ((cur_o & $past(cur_o & catch_en)) == $past(cur_o & catch_en))); // R12
endmodule

// File: rtl/ppm_bit_eval.sv
module ppm_bit_eval #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] prev,
    input  logic [WIDTH-1:0] pat_pol,
    input  logic [WIDTH-1:0] pat_edge,
    input  logic [WIDTH-1:0] pat_mask,
    output logic [WIDTH-1:0] hit_o,
    output logic [WIDTH-1:0] care_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic hit_d;
        always_comb begin
            unique case ({pat_mask[g], pat_edge[g]})
                2'b00:   hit_d = 1'b0;
                2'b01:   hit_d = cur[g] ^ prev[g];
                2'b10:   hit_d = ~(cur[g] ^ pat_pol[g]);
                default: hit_d = pat_pol[g] ? (cur[g] & ~prev[g])
                                            : (~cur[g] & prev[g]);
            endcase
        end
        assign hit_o[g]  = hit_d;
        assign care_o[g] = pat_mask[g] | pat_edge[g];
    end
endmodule

// File: rtl/ppm_combine.sv
module ppm_combine
    import ppm_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] hit,
    input  logic [WIDTH-1:0] care,
    output logic             match_o,
    output logic [IDX_W-1:0] prio_o
);
    logic [WIDTH-1:0] sel;
    logic             all_ok;
    logic             any_ok;
    combine_e         cmode;

    always_comb begin
        cmode  = combine_e'(mode);
        sel    = hit & care;
        all_ok = (care != '0) && ((hit | ~care) == '1);
        any_ok = (sel != '0);
        unique case (cmode)
            CMB_AND:           match_o = all_ok;
            CMB_OR, CMB_PRIO:  match_o = any_ok;
            default:           match_o = 1'b0;
        endcase
        prio_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (sel[i]) prio_o = IDX_W'(i);
        end
    end

    AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> !match_o); // R6
    AST_NO_CARE: assert property (@(posedge clk) disable iff (!rst_n)
        (care == '0) |-> !match_o); // R6
    AST_PRIO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && mode == 2'd3) |-> (hit[prio_o] && care[prio_o])); // R9
    AST_PRIO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && mode == 2'd3) |-> ((sel >> prio_o) == 1)); // R9
endmodule

// File: rtl/port_pattern_matcher.sv
module port_pattern_matcher
    import ppm_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] inv_mask,
    input  logic [WIDTH-1:0] catch_en,
    input  logic [WIDTH-1:0] pat_pol,
    input  logic [WIDTH-1:0] pat_edge,
    input  logic [WIDTH-1:0] pat_mask,
    input  logic [1:0]       combine_mode,
    input  logic             latch_en,
    input  logic             match_only,
    input  logic             flag_clr,
    output logic             match_flag,
    output logic [IDX_W-1:0] prio_idx,
    output logic [WIDTH-1:0] data_out,
    output logic             irq_evt
);
    typedef struct packed {
        logic             flag;
        logic [IDX_W-1:0] prio;
        logic [WIDTH-1:0] data;
        logic             irq;
    } top_t;

    top_t st_d, st_q;

    logic [WIDTH-1:0] cur, prev, hit, care;
    logic             match_now;
    logic [IDX_W-1:0] prio_now;
    logic             freeze;

    ppm_sampler #(.WIDTH(WIDTH)) u_sampler (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .inv_mask(inv_mask),
        .catch_en(catch_en), .flag_clr(flag_clr), .cur_o(cur), .prev_o(prev)
    );

    ppm_bit_eval #(.WIDTH(WIDTH)) u_eval (
        .cur(cur), .prev(prev), .pat_pol(pat_pol), .pat_edge(pat_edge),
        .pat_mask(pat_mask), .hit_o(hit), .care_o(care)
    );

    ppm_combine #(.WIDTH(WIDTH)) u_combine (
        .clk(clk), .rst_n(rst_n), .mode(combine_mode), .hit(hit),
        .care(care), .match_o(match_now), .prio_o(prio_now)
    );

    always_comb begin
        st_d      = st_q;
        freeze    = latch_en && st_q.flag && !flag_clr;
        st_d.flag = match_now || (st_q.flag && !flag_clr);
        if (match_now && combine_e'(combine_mode) == CMB_PRIO)
            st_d.prio = prio_now;
        if (!freeze)
            st_d.data = cur;
        st_d.irq  = match_now || (!match_only && (cur != prev));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match_flag = st_q.flag;
    assign prio_idx   = st_q.prio;
    assign data_out   = st_q.data;
    assign irq_evt    = st_q.irq;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !flag_clr) |=> match_flag); // R10
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        match_now |=> match_flag); // R10
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && match_flag && !flag_clr) |=> $stable(data_out)); // R11
    AST_IRQ_MATCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (match_only && !match_now) |=> !irq_evt); // R13
    AST_PRIO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !match_now |=> $stable(prio_idx)); // R9
endmodule

// File: tb/port_pattern_matcher_bench.sv
module port_pattern_matcher_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_in = '0, inv_mask = '0, catch_en = '0;
    logic [W-1:0] pat_pol = '0, pat_edge = '0, pat_mask = '0;
    logic [1:0]   combine_mode = 2'd0;
    logic         latch_en = 1'b0, match_only = 1'b0, flag_clr = 1'b0;
    logic         match_flag, irq_evt;
    logic [2:0]   prio_idx;
    logic [W-1:0] data_out;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_pattern_matcher #(.WIDTH(W)) u_port_pattern_matcher (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .inv_mask(inv_mask),
        .catch_en(catch_en), .pat_pol(pat_pol), .pat_edge(pat_edge),
        .pat_mask(pat_mask), .combine_mode(combine_mode), .latch_en(latch_en),
        .match_only(match_only), .flag_clr(flag_clr), .match_flag(match_flag),
        .prio_idx(prio_idx), .data_out(data_out), .irq_evt(irq_evt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
    endtask

    task automatic defaults();
        inv_mask = '0; catch_en = '0; pat_pol = '0; pat_edge = '0; pat_mask = '0;
        combine_mode = 2'd0; latch_en = 1'b0; match_only = 1'b0;
        cyc(3);
        clear_flag();
    endtask

    task automatic t_reset();
        chk("R1 flag", match_flag, 0);
        chk("R1 prio", prio_idx, 0);
        chk("R1 data", data_out, 0);
        chk("R1 irq", irq_evt, 0);
    endtask

    task automatic t_level_and();
        defaults();
        combine_mode = 2'd1; pat_mask = 8'h03; pat_pol = 8'h01;
        pin_in = 8'h03; cyc(3); clear_flag();
        chk("R7 partial AND no flag", match_flag, 0);
        pin_in = 8'h01; cyc(2);
        chk("R3 level match flag", match_flag, 1);
        pin_in = 8'h00; cyc(2); clear_flag();
        chk("R3 level zero on bit0 fails", match_flag, 0);
    endtask

    task automatic t_invert();
        defaults();
        pin_in = 8'h00;
        combine_mode = 2'd1; pat_mask = 8'h01; pat_pol = 8'h01; inv_mask = 8'h01;
        cyc(2);
        chk("R2 inverted input matches", match_flag, 1);
        inv_mask = 8'h00; cyc(2); clear_flag();
        chk("R2 no inversion no match", match_flag, 0);
    endtask

    task automatic t_or_prio();
        defaults();
        pin_in = 8'h00;
        combine_mode = 2'd2; pat_mask = 8'h0F; pat_pol = 8'h0F;
        cyc(2); clear_flag();
        chk("R8 no bit no flag", match_flag, 0);
        pin_in = 8'h04; cyc(2);
        chk("R8 one bit sets OR", match_flag, 1);
        combine_mode = 2'd3; pin_in = 8'h0A; cyc(2);
        chk("R9 prio highest bit", prio_idx, 3);
        pin_in = 8'h02; cyc(2);
        chk("R9 prio second match", prio_idx, 1);
        pin_in = 8'h80; cyc(2); clear_flag(); cyc(1);
        chk("R6 masked bit7 ignored", match_flag, 0);
        chk("R9 prio held", prio_idx, 1);
    endtask

    task automatic t_edges();
        defaults();
        pin_in = 8'h00;
        combine_mode = 2'd2; pat_mask = 8'h01; pat_edge = 8'h01; pat_pol = 8'h01;
        cyc(2); clear_flag();
        pin_in = 8'h01; cyc(2);
        chk("R4 rising sets flag", match_flag, 1);
        chk("R13 irq pulse", irq_evt, 1);
        cyc(1);
        chk("R13 irq one cycle", irq_evt, 0);
        clear_flag(); cyc(1);
        chk("R4 edge only one cycle", match_flag, 0);
        pat_pol = 8'h00; pin_in = 8'h00; cyc(2);
        chk("R4 falling sets flag", match_flag, 1);
        clear_flag();
        pin_in = 8'h01; cyc(3);
        chk("R4 rising ignored by falling", match_flag, 0);
        pat_mask = 8'h00; pin_in = 8'h00; cyc(2);
        chk("R5 any transition", match_flag, 1);
    endtask

    task automatic t_disabled();
        defaults();
        pin_in = 8'hFF;
        combine_mode = 2'd0; pat_mask = 8'hFF; pat_pol = 8'hFF;
        cyc(3);
        chk("R6 mode off no flag", match_flag, 0);
        combine_mode = 2'd1; pat_mask = 8'h00; cyc(3);
        chk("R6 all masked AND no flag", match_flag, 0);
    endtask

    task automatic t_latch();
        defaults();
        pin_in = 8'h30;
        combine_mode = 2'd2; pat_mask = 8'h01; pat_pol = 8'h01; latch_en = 1'b1;
        cyc(3); clear_flag();
        pin_in = 8'h31; cyc(2);
        chk("R11 captured data", data_out, 8'h31);
        pin_in = 8'h30; cyc(3);
        chk("R11 data held", data_out, 8'h31);
        clear_flag();
        chk("R11 data resumes", data_out, 8'h30);
        latch_en = 1'b0; pin_in = 8'h5A; cyc(2);
        chk("R11 tracks without latch", data_out, 8'h5A);
    endtask

    task automatic t_catch();
        defaults();
        pin_in = 8'h00; catch_en = 8'h10; cyc(2);
        pin_in = 8'h10; cyc(1);
        pin_in = 8'h00; cyc(3);
        chk("R12 caught one held", data_out, 8'h10);
        clear_flag(); cyc(1);
        chk("R12 cleared", data_out, 8'h00);
    endtask

    task automatic t_irq();
        defaults();
        pin_in = 8'h00; cyc(2);
        pin_in = 8'h40; cyc(2);
        chk("R13 irq on data change", irq_evt, 1);
        match_only = 1'b1; cyc(1);
        pin_in = 8'h00; cyc(2);
        chk("R13 no irq with match only", irq_evt, 0);
    endtask

    initial begin
        cyc(2);
        t_reset();
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_level_and();
        t_invert();
        t_or_prio();
        t_edges();
        t_disabled();
        t_latch();
        t_catch();
        t_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule